// File: doc/BRIEF.md
# Sequential Hardware Breakpoint Controller

This debug block watches the CPU's bus cycles and raises a user break request when configured conditions are met. Every channel holds an address, a don't-care mask and a control word. The control word selects whether the channel looks at instruction fetches or data accesses, marks the condition as a before-execution break, and enables the channel. Channels from a configurable index onward also carry an execution-count countdown. In independent mode any enabled channel that matches raises a break. In sequential mode the channels form a chain in index order. The chain only completes when the channels match in the order of the observed bus cycles.

Configuration goes through a small register-access port. Only accesses tagged with the CPU master identifier are accepted. Every accepted access passes through a fixed-latency pipeline before it reaches the register file, so a setting takes effect a known number of cycles after it is written. A read that follows a write returns the new value. Break events are held pending and are delivered as a one-cycle request once the CPU interrupt-mask input allows it.

Top module: `seq_break_unit`

## Requirements
- R1: A channel matches a bus cycle when the bus address equals the channel address in every bit whose mask bit is 0; mask bits set to 1 are don't-care.
- R2: A channel matches only if its enable bit is set and the cycle type (fetch or data) equals the channel's type; after reset all channels are disabled.
- R3: Register index (4 bits): channel n uses 4n+0 for address, 4n+1 for mask, 4n+2 for control (bit0 fetch type, bit1 before-execution, bit2 enable) and 4n+3 for count; index 14 holds the match flags (bit n = channel n); bit0 of index 15 is sequential mode. An accepted access sampled at clock edge k takes effect at edge k+3, so read data and its one-cycle valid appear after edge k+3 and reflect every earlier write.
- R4: Accesses whose master tag differs from the CPU identifier (0) are ignored: writes change nothing and reads return no valid.
- R5: Match flags are sticky. Writing 0 to a flag bit clears it; writing 1 leaves it unchanged.
- R6: In independent mode every matching channel sets its flag and raises a break event in the same cycle.
- R7: In sequential mode a break event occurs only after channel 0, channel 1, … have matched in that bus-cycle order; a match of a channel that is not the awaited one is ignored.
- R8: In sequential mode, if the awaited channel and the next one are both fetch-type before-execution channels and both match in the same cycle, the chain advances past both and both flags are set; otherwise a same-cycle match advances by one only.
- R9: A channel with a non-zero count decrements it only on a matching instruction fetch, and its match counts only when the count goes from 1 to 0; a count of 0 lets every match count.
- R10: A break event is held pending; break_req is high for one cycle, consuming the event, only while cpu_imask is 14 or below.
- R11: Any applied write to a channel register, to the flags or to the mode register restarts the sequence at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_master | input | MW | Bus master tag of the access |
| acc_idx | input | 4 | Register index |
| acc_wdata | input | 32 | Write data |
| acc_rvalid | output | 1 | Read data valid (one cycle) |
| acc_rdata | output | 32 | Read data |
| bus_valid | input | 1 | Observed bus cycle valid |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_addr | input | 32 | Observed bus address |
| cpu_imask | input | 4 | CPU interrupt-mask level |
| break_req | output | 1 | Break request delivered to the CPU |
| match_flags | output | NCH | Sticky per-channel match flags |

## Verification
The comparators are tried with an address inside the masked window, one just outside it, and the right address with the wrong cycle type. These separate the mask handling from the type check. Sequential mode is driven with the second channel first, then the first, then the second again, which shows ordering by bus cycle rather than by mere occurrence. A single fetch that hits two chained channels is run both with and without the before-execution setting, to tell the same-cycle rule apart from plain advancing. Countdown, mask-level holding and restart on rewrite are each shown by comparing whether a break fires before and after the triggering change.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int A_W  = 32;
  localparam int D_W  = 32;
  localparam int R_W  = 4;
  localparam int CH_W = R_W - 2;
  localparam logic [R_W-1:0] REG_FLAGS = 4'hE;
  localparam logic [R_W-1:0] REG_MODE  = 4'hF;

  typedef enum logic [1:0] {
    F_ADDR = 2'd0,
    F_MASK = 2'd1,
    F_CTRL = 2'd2,
    F_CNT  = 2'd3
  } field_e;

  typedef struct packed {
    logic           wr;
    logic [R_W-1:0] idx;
    logic [D_W-1:0] data;
  } acc_t;

  typedef struct packed {
    logic [A_W-1:0] addr;
    logic [A_W-1:0] mask;
    logic           fetch;
    logic           pre;
    logic           en;
  } chan_cfg_t;
endpackage

// File: rtl/sbu_acc_pipe.sv
module sbu_acc_pipe
  import sbu_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  acc_t in_req,
  output logic out_vld,
  output acc_t out_req
);
  genvar s;
  generate
    for (s = 0; s < LAT; s++) begin : g_stage
      logic vq;
      acc_t rq;
      logic vd;
      acc_t rd;
      if (s == 0) begin : g_head
        assign vd = in_vld;
        assign rd = in_req;
      end else begin : g_tail
        assign vd = g_stage[s-1].vq;
        assign rd = g_stage[s-1].rq;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vq <= 1'b0;
        else        vq <= vd;
      end
      always_ff @(posedge clk) begin
        if (vd) rq <= rd;
      end
    end
  endgenerate

  assign out_vld = g_stage[LAT-1].vq;
  assign out_req = g_stage[LAT-1].rq;
endmodule

// File: rtl/sbu_chan_match.sv
module sbu_chan_match
  import sbu_pkg::*;
(
  input  chan_cfg_t      cfg,
  input  logic           bus_vld,
  input  logic           bus_fetch,
  input  logic [A_W-1:0] bus_addr,
  output logic           hit
);
  logic [A_W-1:0] diff;
  always_comb begin
    diff = (bus_addr ^ cfg.addr) & ~cfg.mask;
    hit  = cfg.en & bus_vld & (bus_fetch == cfg.fetch) & (diff == '0);
  end
endmodule

// File: rtl/sbu_seq_track.sv
module sbu_seq_track #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seq_en,
  input  logic           restart,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] chain,
  output logic           fire,
  output logic [NCH-1:0] set_flags
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IW-1:0]  pos_q, pos_d;
  logic [NCH-1:0] chain_nx;
  assign chain_nx = chain >> 1;

  always_comb begin
    int   pos;
    logic go;
    fire      = 1'b0;
    set_flags = '0;
    pos_d     = pos_q;
    pos       = int'(pos_q);
    go        = 1'b1;
    if (!seq_en) begin
      set_flags = hit;
      fire      = |hit;
      pos_d     = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (go && c == pos) begin
          if (hit[c]) begin
            set_flags[c] = 1'b1;
            pos          = c + 1;
            go           = chain[c] & chain_nx[c];
          end else begin
            go = 1'b0;
          end
        end
      end
      if (pos >= NCH) begin
        fire  = 1'b1;
        pos_d = '0;
      end else begin
        pos_d = IW'(pos);
      end
    end
    if (restart) pos_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/seq_break_unit.sv
module seq_break_unit
  import sbu_pkg::*;
#(
  parameter int             NCH      = 2,
  parameter int             CNT_W    = 8,
  parameter int             LAT      = 3,
  parameter int             MW       = 2,
  parameter logic [MW-1:0]  CPU_ID   = '0,
  parameter int             IM_W     = 4,
  parameter int             MASK_LIM = 14,
  parameter int             CNT_FROM = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [MW-1:0]    acc_master,
  input  logic [R_W-1:0]   acc_idx,
  input  logic [D_W-1:0]   acc_wdata,
  output logic             acc_rvalid,
  output logic [D_W-1:0]   acc_rdata,
  input  logic             bus_valid,
  input  logic             bus_fetch,
  input  logic [A_W-1:0]   bus_addr,
  input  logic [IM_W-1:0]  cpu_imask,
  output logic             break_req,
  output logic [NCH-1:0]   match_flags
);
  // Access path: master filter, then fixed-latency pipeline
  acc_t in_req, p_req;
  logic in_vld, p_vld;
  assign in_vld = acc_valid & (acc_master == CPU_ID);
  assign in_req = '{wr: acc_write, idx: acc_idx, data: acc_wdata};

  sbu_acc_pipe #(.LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_req(in_req),
    .out_vld(p_vld), .out_req(p_req)
  );

  logic            ap_wr, ap_rd, chan_wr, flag_wr, mode_wr, restart;
  logic [CH_W-1:0] ap_ch;
  field_e          ap_fld;
  assign ap_wr   = p_vld & p_req.wr;
  assign ap_rd   = p_vld & ~p_req.wr;
  assign ap_ch   = p_req.idx[R_W-1:2];
  assign ap_fld  = field_e'(p_req.idx[1:0]);
  assign chan_wr = ap_wr & (int'(ap_ch) < NCH);
  assign flag_wr = ap_wr & (p_req.idx == REG_FLAGS);
  assign mode_wr = ap_wr & (p_req.idx == REG_MODE);
  assign restart = chan_wr | flag_wr | mode_wr;

  logic [NCH-1:0]          raw, hit, chain, set_flags;
  logic [NCH-1:0][D_W-1:0] rd_chan;
  logic                    fire;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      chan_cfg_t       cfg_q, cfg_d;
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic            sel;
      assign sel = chan_wr & (ap_ch == CH_W'(c));

      sbu_chan_match u_match (
        .cfg(cfg_q), .bus_vld(bus_valid), .bus_fetch(bus_fetch),
        .bus_addr(bus_addr), .hit(raw[c])
      );

      always_comb begin
        cfg_d = cfg_q;
        if (sel && ap_fld == F_ADDR) cfg_d.addr = p_req.data[A_W-1:0];
        if (sel && ap_fld == F_MASK) cfg_d.mask = p_req.data[A_W-1:0];
        if (sel && ap_fld == F_CTRL) begin
          cfg_d.fetch = p_req.data[0];
          cfg_d.pre   = p_req.data[1];
          cfg_d.en    = p_req.data[2];
        end
      end

      if (c >= CNT_FROM) begin : g_cnt
        logic armed;
        assign armed = (cnt_q != '0);
        always_comb begin
          cnt_d = cnt_q;
          if (sel && ap_fld == F_CNT)          cnt_d = p_req.data[CNT_W-1:0];
          else if (raw[c] && bus_fetch && armed) cnt_d = cnt_q - 1'b1;
        end
        assign hit[c] = raw[c] & (~armed | (bus_fetch & (cnt_q == CNT_W'(1))));
      end else begin : g_nocnt
        assign cnt_d  = '0;
        assign hit[c] = raw[c];
      end

      assign chain[c] = cfg_q.fetch & cfg_q.pre;

      always_comb begin
        case (ap_fld)
          F_ADDR:  rd_chan[c] = D_W'(cfg_q.addr);
          F_MASK:  rd_chan[c] = D_W'(cfg_q.mask);
          F_CTRL:  rd_chan[c] = D_W'({cfg_q.en, cfg_q.pre, cfg_q.fetch});
          default: rd_chan[c] = D_W'(cnt_q);
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q <= '0;
          cnt_q <= '0;
        end else begin
          cfg_q <= cfg_d;
          cnt_q <= cnt_d;
        end
      end
    end
  endgenerate

  sbu_seq_track #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .seq_en(mode_q), .restart(restart),
    .hit(hit), .chain(chain), .fire(fire), .set_flags(set_flags)
  );

  // Global state: mode, flags, pending break, read return
  logic           mode_q, mode_d;
  logic [NCH-1:0] flags_q, flags_d;
  logic           pend_q, pend_d, deliver;
  logic           rvalid_q;
  logic [D_W-1:0] rdata_q, rdata_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = p_req.data[0];
    flags_d = flags_q;
    if (flag_wr) flags_d = flags_q & p_req.data[NCH-1:0];
    flags_d = flags_d | set_flags;
    deliver = pend_q & (cpu_imask <= IM_W'(MASK_LIM));
    pend_d  = (pend_q & ~deliver) | fire;
    rdata_d = rdata_q;
    if (ap_rd) begin
      rdata_d = '0;
      if (p_req.idx == REG_FLAGS)     rdata_d = D_W'(flags_q);
      else if (p_req.idx == REG_MODE) rdata_d = D_W'(mode_q);
      else begin
        for (int k = 0; k < NCH; k++)
          if (ap_ch == CH_W'(k)) rdata_d = rd_chan[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      flags_q  <= '0;
      pend_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      flags_q  <= flags_d;
      pend_q   <= pend_d;
      rvalid_q <= ap_rd;
      rdata_q  <= rdata_d;
    end
  end

  assign break_req   = deliver;
  assign match_flags = flags_q;
  assign acc_rvalid  = rvalid_q;
  assign acc_rdata   = rdata_q;
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
  parameter int            NCH      = 2,
  parameter int            LAT      = 3,
  parameter int            MW       = 2,
  parameter logic [MW-1:0] CPU_ID   = '0,
  parameter int            IM_W     = 4,
  parameter int            MASK_LIM = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            acc_write,
  input logic [MW-1:0]   acc_master,
  input logic            acc_rvalid,
  input logic [IM_W-1:0] cpu_imask,
  input logic            break_req,
  input logic [NCH-1:0]  match_flags,
  input logic            flag_wr,
  input logic            fire
);
  logic [LAT-1:0] rd_sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_sr <= '0;
    else        rd_sr <= (rd_sr << 1) | LAT'(acc_valid && !acc_write && acc_master == CPU_ID);
  end

  // R3 latency of the read return; R4 foreign reads never return
  assert_read_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid == $past(rd_sr[LAT-1]));

  assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |-> (cpu_imask <= IM_W'(MASK_LIM)));

  assert_single_delivery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    break_req |=> (!break_req || $past(fire)));

  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((match_flags & $past(match_flags)) == $past(match_flags)));
endmodule

bind seq_break_unit sbu_checker #(
  .NCH(NCH), .LAT(LAT), .MW(MW), .CPU_ID(CPU_ID), .IM_W(IM_W), .MASK_LIM(MASK_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_master(acc_master), .acc_rvalid(acc_rvalid), .cpu_imask(cpu_imask),
  .break_req(break_req), .match_flags(match_flags), .flag_wr(flag_wr), .fire(fire)
);

// File: tb/seq_break_unit_tb.sv
module seq_break_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_master;
  logic [3:0]  acc_idx;
  logic [31:0] acc_wdata;
  logic        acc_rvalid;
  logic [31:0] acc_rdata;
  logic        bus_valid, bus_fetch;
  logic [31:0] bus_addr;
  logic [3:0]  cpu_imask;
  logic        break_req;
  logic [1:0]  match_flags;

  int n_chk = 0;
  int n_err = 0;

  seq_break_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_master(acc_master), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata), .bus_valid(bus_valid),
    .bus_fetch(bus_fetch), .bus_addr(bus_addr), .cpu_imask(cpu_imask),
    .break_req(break_req), .match_flags(match_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d, input logic [1:0] m = 2'd0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_idx = idx; acc_wdata = d; acc_master = m;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_master = 2'd0;
  endtask

  task automatic settle;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] idx, input logic [1:0] m, output logic [31:0] d, output int lat);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_idx = idx; acc_master = m;
    @(negedge clk);
    acc_valid = 1'b0; acc_master = 2'd0;
    lat = 1;
    while (!acc_rvalid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    d = acc_rdata;
  endtask

  task automatic bus(input logic [31:0] a, input logic f, output logic brk, output logic [1:0] fl);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_fetch = f;
    @(negedge clk);
    bus_valid = 1'b0;
    brk = break_req;
    fl  = match_flags;
  endtask

  task automatic clear_flags;
    wr(4'hE, 32'h0);
    settle();
  endtask

  task automatic t_reset;
    logic [31:0] d; int lat; logic b; logic [1:0] fl;
    check("R2 reset break_req", 32'(break_req), 0);
    check("R5 reset flags", 32'(match_flags), 0);
    rd(4'd2, 2'd0, d, lat);
    check("R2 reset ctrl ch0", d, 0);
    bus(32'h0, 1'b0, b, fl);
    check("R2 disabled channel no break", 32'(b), 0);
  endtask

  task automatic t_latency;
    logic [31:0] d; int lat;
    wr(4'd0, 32'h1234);
    rd(4'd0, 2'd0, d, lat);
    check("R3 read after write data", d, 32'h1234);
    check("R3 read return cycle", 32'(lat), 4);
    wr(4'd0, 32'h40);
    settle();
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_idx = 4'd2; acc_wdata = 32'h4;
    bus_valid = 1'b1; bus_addr = 32'h40; bus_fetch = 1'b0;
    @(negedge clk); acc_valid = 1'b0; acc_write = 1'b0;
    check("R3 flag after k", 32'(match_flags), 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R3 flag after k+3", 32'(match_flags), 0);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R3 flag after k+4", 32'(match_flags), 1);
    wr(4'd2, 32'h0);
    clear_flags();
  endtask

  task automatic t_match;
    logic b; logic [1:0] fl;
    wr(4'd0, 32'h1000); wr(4'd1, 32'hF); wr(4'd2, 32'h4);
    wr(4'd4, 32'h2000); wr(4'd6, 32'h5);
    settle();
    bus(32'h100A, 1'b0, b, fl);
    check("R1 masked hit break", 32'(b), 1);
    check("R1 masked hit flags", 32'(fl), 1);
    clear_flags();
    bus(32'h1010, 1'b0, b, fl);
    check("R1 outside window", 32'(fl), 0);
    bus(32'h1000, 1'b1, b, fl);
    check("R2 wrong type no match", 32'(fl), 0);
    check("R2 wrong type no break", 32'(b), 0);
    bus(32'h2000, 1'b1, b, fl);
    check("R6 independent ch1 break", 32'(b), 1);
    check("R6 independent ch1 flag", 32'(fl), 2);
  endtask

  task automatic t_flags;
    logic b; logic [1:0] fl;
    bus(32'h1000, 1'b0, b, fl);
    check("R5 both flags set", 32'(fl), 3);
    wr(4'hE, 32'h3); settle();
    check("R5 write one keeps", 32'(match_flags), 3);
    wr(4'hE, 32'h2); settle();
    check("R5 write zero clears bit0", 32'(match_flags), 2);
    clear_flags();
    check("R5 all cleared", 32'(match_flags), 0);
  endtask

  task automatic t_master;
    logic [31:0] d; int lat;
    wr(4'd0, 32'hDEAD, 2'd1);
    settle();
    rd(4'd0, 2'd0, d, lat);
    check("R4 foreign write ignored", d, 32'h1000);
    rd(4'd0, 2'd2, d, lat);
    check("R4 foreign read no return", 32'(lat), 8);
  endtask

  task automatic t_seq;
    logic b; logic [1:0] fl;
    wr(4'hF, 32'h1);
    settle();
    bus(32'h2000, 1'b1, b, fl);
    check("R7 second first ignored", 32'(fl), 0);
    bus(32'h1000, 1'b0, b, fl);
    check("R7 first step no break", 32'(b), 0);
    check("R7 first step flag", 32'(fl), 1);
    bus(32'h2000, 1'b1, b, fl);
    check("R7 ordered sequence break", 32'(b), 1);
    check("R7 ordered sequence flags", 32'(fl), 3);
    clear_flags();
    bus(32'h1000, 1'b0, b, fl);
    wr(4'd6, 32'h5);
    settle();
    bus(32'h2000, 1'b1, b, fl);
    check("R11 restart after rewrite", 32'(b), 0);
    check("R11 restart flags", 32'(fl), 1);
    clear_flags();
  endtask

  task automatic t_simul;
    logic b; logic [1:0] fl;
    wr(4'd0, 32'h2000); wr(4'd1, 32'h0); wr(4'd2, 32'h7); wr(4'd6, 32'h7);
    clear_flags();
    bus(32'h2000, 1'b1, b, fl);
    check("R8 chained same cycle break", 32'(b), 1);
    check("R8 chained same cycle flags", 32'(fl), 3);
    wr(4'd2, 32'h5);
    clear_flags();
    bus(32'h2000, 1'b1, b, fl);
    check("R8 not pre no break", 32'(b), 0);
    check("R8 not pre one step", 32'(fl), 1);
    wr(4'hF, 32'h0); wr(4'd2, 32'h0);
    clear_flags();
  endtask

  task automatic t_count;
    logic b; logic [1:0] fl; logic [31:0] d; int lat;
    wr(4'd6, 32'h5); wr(4'd7, 32'h3);
    settle();
    bus(32'h2000, 1'b1, b, fl);
    check("R9 first fetch no break", 32'(b), 0);
    bus(32'h2000, 1'b1, b, fl);
    check("R9 second fetch no break", 32'(b), 0);
    rd(4'd7, 2'd0, d, lat);
    check("R9 count after two", d, 1);
    bus(32'h2000, 1'b1, b, fl);
    check("R9 reaches zero break", 32'(b), 1);
    rd(4'd7, 2'd0, d, lat);
    check("R9 count zero", d, 0);
    bus(32'h2000, 1'b1, b, fl);
    check("R9 zero breaks every match", 32'(b), 1);
    wr(4'd7, 32'h2); settle();
    bus(32'h2000, 1'b0, b, fl);
    rd(4'd7, 2'd0, d, lat);
    check("R9 no fetch no decrement", d, 2);
    wr(4'd7, 32'h0);
    clear_flags();
  endtask

  task automatic t_pend;
    logic b; logic [1:0] fl;
    cpu_imask = 4'd15;
    bus(32'h2000, 1'b1, b, fl);
    check("R10 masked at 15", 32'(b), 0);
    repeat (3) @(negedge clk);
    check("R10 still held", 32'(break_req), 0);
    cpu_imask = 4'd14;
    #1;
    check("R10 delivered at 14", 32'(break_req), 1);
    @(negedge clk);
    check("R10 consumed", 32'(break_req), 0);
    cpu_imask = 4'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_master = 2'd0; acc_idx = 4'd0; acc_wdata = 32'd0;
    bus_valid = 1'b0; bus_fetch = 1'b0; bus_addr = 32'd0; cpu_imask = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_match();
    t_flags();
    t_master();
    t_seq();
    t_simul();
    t_count();
    t_pend();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule